// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a DDR SDRAM command bus: clock enable, chip select, the three strobes, the bank address and address bit 10. It turns them into a single named command code each cycle. It follows the power state of the memory through power-down and self-refresh, and for every bank it keeps whether a row is open and which row that is. It is intended for a memory controller's protocol monitor, or for a model that has to know the state of the device the controller is driving.

Each command is checked against the tracked state before it takes effect. A command that breaks the sequencing rules raises a one-cycle error flag and changes nothing. These commands are: a read or write to a closed bank, an activate to an open bank, a mode-register write, refresh or self-refresh entry while a bank is open, a read or write while a write with auto-precharge is still bursting, and a clock-enable drop together with a command other than refresh or no-op. All outputs are registered, so the effect of the command sampled at a rising edge is visible right after that edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With clock enable high on this cycle and the previous one, and chip select low, the strobes {RAS#,CAS#,WE#} decode as follows. 000 is mode write (code 1), 001 is refresh (code 2), 011 is activate (code 3), 101 is read (code 4), 100 is write (code 5), 110 is burst stop (code 6), 010 is precharge (code 7) and 111 is no-op (code 0). The code appears on `cmd_o` after the sampling edge.
- R2: A high chip select decodes as no-op (code 0), whatever the strobes are.
- R3: A legal activate sets the open bit of bank `ba` in `bank_open_o` (bit n is bank n) and stores `row_addr` in that bank's field of `open_row_o` (bits n*ROW_W and up).
- R4: Precharge with `a10` low closes only bank `ba`. With `a10` high it closes every bank and `ba` has no effect.
- R5: A read with `a10` high closes its bank at once. A write with `a10` high keeps its bank open and holds `wr_ap_busy_o` high for BL/2 cycles, then closes the bank as busy drops. BL is taken from `bl_cfg`: 0 gives 2, 1 gives 4, 2 or 3 gives 8.
- R6: A read or write to a closed bank, or an activate to an open bank, raises `err_o` for one cycle and leaves the bank state unchanged.
- R7: Mode write, refresh or self-refresh entry while any bank is open raises `err_o` and changes neither the bank state nor the power state.
- R8: A read or write issued while `wr_ap_busy_o` is high raises `err_o` and is ignored.
- R9: Clock enable falling with the refresh pattern enters self-refresh (code 8, `pwr_o` = 3). Clock enable rising while in self-refresh exits it (code 9, `pwr_o` = 0).
- R10: Clock enable falling with a no-op or a high chip select enters power-down (code 10). `pwr_o` becomes 1 if a bank is open and 2 otherwise. Clock enable rising exits power-down (code 11, `pwr_o` = 0).
- R11: While clock enable is low on this cycle and the previous one, the other pins are ignored and the code is no-op.
- R12: Clock enable falling with any command other than refresh or no-op decodes as code 12 and raises `err_o`.
- R13: After reset all outputs are zero: no-op code, no error, all banks closed, normal power state, not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| row_addr | input | ROW_W | Row address sampled on activate |
| bl_cfg | input | 2 | Burst length setting |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Sequencing error for the last command |
| bank_open_o | output | NUM_BANKS | Per-bank open flag |
| open_row_o | output | NUM_BANKS*ROW_W | Open row of each bank |
| pwr_o | output | 2 | Power state: 0 run, 1 active power-down, 2 precharge power-down, 3 self-refresh |
| wr_ap_busy_o | output | 1 | Write burst with auto-precharge in progress |

## Verification
The embedded properties check, on every cycle, that refresh or mode writes against an open bank, reads to closed banks and accesses during an auto-precharge write burst all produce the error flag. They also check that self-refresh and precharge power-down never coexist with an open bank, and that the write-burst window closes when its counter expires. The bench scenarios alone show the actual decode table, that rejected commands leave the row fields and open flags untouched, the exact burst-length windows for two settings, all-bank precharge ignoring the bank address, and the pins being ignored while clock enable stays low.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_ACT  = 4'd3,
        CMD_RD   = 4'd4,
        CMD_WR   = 4'd5,
        CMD_BST  = 4'd6,
        CMD_PRE  = 4'd7,
        CMD_SRE  = 4'd8,
        CMD_SRX  = 4'd9,
        CMD_PDE  = 4'd10,
        CMD_PDX  = 4'd11,
        CMD_ILL  = 4'd12
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_APD  = 2'd1,
        PWR_PPD  = 2'd2,
        PWR_SELF = 2'd3
    } pwr_e;

    // Clock cycles a double-rate burst occupies: half the burst length.
    function automatic logic [3:0] burst_cycles(input logic [1:0] cfg);
        case (cfg)
            2'd0:    burst_cycles = 4'd1;
            2'd1:    burst_cycles = 4'd2;
            default: burst_cycles = 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cke_prev,
    input  logic cke_now,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  pwr_e pwr,
    output cmd_e cmd
);

    logic [2:0] strobes;
    cmd_e       base;

    assign strobes = {ras_n, cas_n, we_n};

    // Strobe pattern alone, clock enable not considered.
    always_comb begin
        if (cs_n) begin
            base = CMD_NOP;
        end else begin
            case (strobes)
                3'b000:  base = CMD_MRS;
                3'b001:  base = CMD_REF;
                3'b011:  base = CMD_ACT;
                3'b101:  base = CMD_RD;
                3'b100:  base = CMD_WR;
                3'b110:  base = CMD_BST;
                3'b010:  base = CMD_PRE;
                default: base = CMD_NOP;
            endcase
        end
    end

    // Clock enable history selects normal, entry, exit or hold decode.
    always_comb begin
        if (cke_prev && cke_now) begin
            cmd = base;
        end else if (cke_prev && !cke_now) begin
            if (base == CMD_NOP)      cmd = CMD_PDE;
            else if (base == CMD_REF) cmd = CMD_SRE;
            else                      cmd = CMD_ILL;
        end else if (!cke_prev && cke_now) begin
            if (pwr == PWR_SELF)                         cmd = CMD_SRX;
            else if (pwr == PWR_APD || pwr == PWR_PPD)   cmd = CMD_PDX;
            else                                         cmd = CMD_NOP;
        end else begin
            cmd = CMD_NOP;
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (open_req) begin
            slot_d.open = 1'b1;
            slot_d.row  = row_in;
        end else if (close_req) begin
            slot_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign open_o = slot_q.open;
    assign row_o  = slot_q.row;

endmodule

// File: rtl/sdram_wrap_guard.sv
module sdram_wrap_guard
    import sdram_trk_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int CNT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      bl_cfg,
    input  logic [BA_W-1:0] bank_in,
    output logic            busy_o,
    output logic            expire_o,
    output logic [BA_W-1:0] bank_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BA_W-1:0]  bank;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (start) begin
            g_d.cnt  = CNT_W'(burst_cycles(bl_cfg));
            g_d.bank = bank_in;
        end else if (g_q.cnt != '0) begin
            g_d.cnt = g_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign busy_o   = (g_q.cnt != '0);
    assign expire_o = (g_q.cnt == CNT_W'(1));
    assign bank_o   = g_q.bank;

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic                       a10,
    input  logic [ROW_W-1:0]           row_addr,
    input  logic [1:0]                 bl_cfg,
    output logic [3:0]                 cmd_o,
    output logic                       err_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
    output logic [1:0]                 pwr_o,
    output logic                       wr_ap_busy_o
);

    localparam int CNT_W = 4;

    typedef struct packed {
        logic cke_prev;
        pwr_e pwr;
        cmd_e cmd;
        logic err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    cmd_e                 dec_cmd;
    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] open_req;
    logic [NUM_BANKS-1:0] close_req;
    logic                 wr_start;
    logic                 wr_busy;
    logic                 wr_expire;
    logic [BA_W-1:0]      wr_bank;
    logic                 any_open;
    logic                 hit;
    logic                 bad;

    sdram_cmd_decode u_dec (
        .cke_prev (ctl_q.cke_prev),
        .cke_now  (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .pwr      (ctl_q.pwr),
        .cmd      (dec_cmd)
    );

    sdram_wrap_guard #(
        .BA_W  (BA_W),
        .CNT_W (CNT_W)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_start),
        .bl_cfg   (bl_cfg),
        .bank_in  (ba),
        .busy_o   (wr_busy),
        .expire_o (wr_expire),
        .bank_o   (wr_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_slot #(
            .ROW_W (ROW_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[b]),
            .close_req (close_req[b]),
            .row_in    (row_addr),
            .open_o    (open_vec[b]),
            .row_o     (open_row_o[b*ROW_W +: ROW_W])
        );
    end

    assign any_open = |open_vec;
    assign hit      = open_vec[ba];

    // Legality of the decoded command against tracked state.
    always_comb begin
        case (dec_cmd)
            CMD_MRS, CMD_REF, CMD_SRE: bad = any_open;
            CMD_ACT:                   bad = hit;
            CMD_RD, CMD_WR:            bad = !hit || wr_busy;
            CMD_ILL:                   bad = 1'b1;
            default:                   bad = 1'b0;
        endcase
    end

    // Next state and per-bank requests.
    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.cke_prev = cke;
        ctl_d.cmd      = dec_cmd;
        ctl_d.err      = bad;
        open_req       = '0;
        close_req      = '0;
        wr_start       = 1'b0;
        if (wr_expire) close_req[wr_bank] = 1'b1;
        if (!bad) begin
            case (dec_cmd)
                CMD_ACT: open_req[ba] = 1'b1;
                CMD_RD:  if (a10) close_req[ba] = 1'b1;
                CMD_WR:  wr_start = a10;
                CMD_PRE: begin
                    if (a10) close_req     = '1;
                    else     close_req[ba] = 1'b1;
                end
                CMD_SRE: ctl_d.pwr = PWR_SELF;
                CMD_PDE: ctl_d.pwr = any_open ? PWR_APD : PWR_PPD;
                CMD_SRX, CMD_PDX: ctl_d.pwr = PWR_RUN;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cmd_o        = ctl_q.cmd;
    assign err_o        = ctl_q.err;
    assign pwr_o        = ctl_q.pwr;
    assign bank_open_o  = open_vec;
    assign wr_ap_busy_o = wr_busy;

    // R6
    rd_idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_cmd == CMD_RD || dec_cmd == CMD_WR) && !open_vec[ba]) |=> err_o);

    // R7
    open_bank_maint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_cmd == CMD_MRS || dec_cmd == CMD_REF || dec_cmd == CMD_SRE) && any_open) |=> err_o);

    // R8
    burst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && (dec_cmd == CMD_RD || dec_cmd == CMD_WR)) |=> err_o);

    // R5
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && wr_expire) |=> !wr_busy);

    // R9
    self_ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pwr == PWR_SELF) |-> (open_vec == '0));

    // R10
    pre_pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pwr == PWR_PPD) |-> (open_vec == '0));

endmodule

// File: tb/sdram_cmd_tracker_test.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_test;

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_DES = 4'b1000;
    localparam logic [3:0] P_DSH = 4'b1111;
    localparam logic [3:0] P_MRS = 4'b0000;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_BST = 4'b0110;
    localparam logic [3:0] P_PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic [12:0] row_addr = '0;
    logic [1:0]  bl_cfg = 2'd1;
    logic [3:0]  cmd_o;
    logic        err_o;
    logic [3:0]  bank_open_o;
    logic [51:0] open_row_o;
    logic [1:0]  pwr_o;
    logic        wr_ap_busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic [3:0]  cmd;
        logic        err;
        logic [3:0]  open;
        logic [1:0]  pwr;
        logic        busy;
        int          rb;
        logic [12:0] rv;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    sdram_cmd_tracker uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .row_addr(row_addr),
        .bl_cfg(bl_cfg), .cmd_o(cmd_o), .err_o(err_o), .bank_open_o(bank_open_o),
        .open_row_o(open_row_o), .pwr_o(pwr_o), .wr_ap_busy_o(wr_ap_busy_o)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic ck, input logic [3:0] pins,
                        input logic [1:0] b, input logic ap, input logic [12:0] r,
                        input logic [3:0] ec, input logic ee, input logic [3:0] eo,
                        input logic [1:0] ep, input logic eb,
                        input int rb = -1, input logic [12:0] rv = '0);
        exp_t e;
        @(negedge clk);
        cke = ck;
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba = b; a10 = ap; row_addr = r;
        e.tag = tag; e.cmd = ec; e.err = ee; e.open = eo; e.pwr = ep; e.busy = eb;
        e.rb = rb; e.rv = rv;
        sb.push_back(e);
    endtask

    // Monitor: compares registered outputs just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "cmd",  16'(cmd_o),        16'(e.cmd));
                chk(e.tag, "err",  16'(err_o),        16'(e.err));
                chk(e.tag, "open", 16'(bank_open_o),  16'(e.open));
                chk(e.tag, "pwr",  16'(pwr_o),        16'(e.pwr));
                chk(e.tag, "busy", 16'(wr_ap_busy_o), 16'(e.busy));
                if (e.rb >= 0)
                    chk(e.tag, "row", 16'(open_row_o[e.rb*13 +: 13]), 16'(e.rv));
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state at the ports
        chk("R13", "cmd",  16'(cmd_o), 16'd0);
        chk("R13", "err",  16'(err_o), 16'd0);
        chk("R13", "open", 16'(bank_open_o), 16'd0);
        chk("R13", "pwr",  16'(pwr_o), 16'd0);
        chk("R13", "busy", 16'(wr_ap_busy_o), 16'd0);
        rst_n = 1'b1;

        step("R13 first nop", 1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0000, 0, 0);
        step("R2 deselect",   1, P_DES, 0, 0, 0, 4'd0, 0, 4'b0000, 0, 0);
        step("R1 mode write", 1, P_MRS, 0, 0, 0, 4'd1, 0, 4'b0000, 0, 0);
        step("R1 refresh",    1, P_REF, 0, 0, 0, 4'd2, 0, 4'b0000, 0, 0);
        step("R3 act b1",     1, P_ACT, 1, 0, 13'h123, 4'd3, 0, 4'b0010, 0, 0, 1, 13'h123);
        step("R3 act b2",     1, P_ACT, 2, 0, 13'h0AA, 4'd3, 0, 4'b0110, 0, 0, 2, 13'h0AA);
        step("R6 act open",   1, P_ACT, 1, 0, 13'h555, 4'd3, 1, 4'b0110, 0, 0, 1, 13'h123);
        step("R6 rd idle",    1, P_RD,  0, 0, 0, 4'd4, 1, 4'b0110, 0, 0);
        step("R1 read",       1, P_RD,  1, 0, 0, 4'd4, 0, 4'b0110, 0, 0);
        step("R1 burst stop", 1, P_BST, 0, 0, 0, 4'd6, 0, 4'b0110, 0, 0);
        step("R7 mrs open",   1, P_MRS, 0, 0, 0, 4'd1, 1, 4'b0110, 0, 0);
        step("R7 ref open",   1, P_REF, 0, 0, 0, 4'd2, 1, 4'b0110, 0, 0);
        step("R4 pre b2",     1, P_PRE, 2, 0, 0, 4'd7, 0, 4'b0010, 0, 0);
        step("R5 rd autopre", 1, P_RD,  1, 1, 0, 4'd4, 0, 4'b0000, 0, 0);
        step("R3 act b3",     1, P_ACT, 3, 0, 13'h1FF, 4'd3, 0, 4'b1000, 0, 0, 3, 13'h1FF);
        step("R3 act b0",     1, P_ACT, 0, 0, 13'h010, 4'd3, 0, 4'b1001, 0, 0);
        step("R5 wr ap bl4",  1, P_WR,  3, 1, 0, 4'd5, 0, 4'b1001, 0, 1);
        step("R8 rd busy",    1, P_RD,  0, 0, 0, 4'd4, 1, 4'b1001, 0, 1);
        step("R5 bl4 end",    1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0001, 0, 0);
        step("R5 wr after",   1, P_WR,  0, 0, 0, 4'd5, 0, 4'b0001, 0, 0);
        step("R4 act b2",     1, P_ACT, 2, 0, 13'h0F0, 4'd3, 0, 4'b0101, 0, 0, 2, 13'h0F0);
        step("R4 pre all",    1, P_PRE, 1, 1, 0, 4'd7, 0, 4'b0000, 0, 0);

        @(negedge clk); bl_cfg = 2'd2;
        step("R5 act b1",     1, P_ACT, 1, 0, 13'h007, 4'd3, 0, 4'b0010, 0, 0);
        step("R5 wr ap bl8",  1, P_WR,  1, 1, 0, 4'd5, 0, 4'b0010, 0, 1);
        step("R5 bl8 c2",     1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0010, 0, 1);
        step("R5 bl8 c3",     1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0010, 0, 1);
        step("R5 bl8 c4",     1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0010, 0, 1);
        step("R5 bl8 end",    1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0000, 0, 0);

        step("R10 act b0",    1, P_ACT, 0, 0, 13'h001, 4'd3, 0, 4'b0001, 0, 0);
        step("R10 apd entry", 0, P_NOP, 0, 0, 0, 4'd10, 0, 4'b0001, 1, 0);
        step("R11 pins held", 0, P_ACT, 2, 0, 0, 4'd0, 0, 4'b0001, 1, 0);
        step("R10 apd exit",  1, P_NOP, 0, 0, 0, 4'd11, 0, 4'b0001, 0, 0);
        step("R7 sref open",  0, P_REF, 0, 0, 0, 4'd8, 1, 4'b0001, 0, 0);
        step("R7 after sref", 1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0001, 0, 0);
        step("R4 pre b0",     1, P_PRE, 0, 0, 0, 4'd7, 0, 4'b0000, 0, 0);
        step("R10 ppd entry", 0, P_DSH, 0, 0, 0, 4'd10, 0, 4'b0000, 2, 0);
        step("R10 ppd exit",  1, P_NOP, 0, 0, 0, 4'd11, 0, 4'b0000, 0, 0);
        step("R9 sref entry", 0, P_REF, 0, 0, 0, 4'd8, 0, 4'b0000, 3, 0);
        step("R11 sref hold", 0, P_MRS, 0, 0, 0, 4'd0, 0, 4'b0000, 3, 0);
        step("R9 sref exit",  1, P_NOP, 0, 0, 0, 4'd9, 0, 4'b0000, 0, 0);
        step("R12 cke drop",  0, P_ACT, 0, 0, 0, 4'd12, 1, 4'b0000, 0, 0);
        step("R12 recover",   1, P_NOP, 0, 0, 0, 4'd0, 0, 4'b0000, 0, 0);

        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule